// File: doc/BRIEF.md
# Polarity-Selectable PWM Channel Timer

This block is one channel of a pulse-width modulator. An 8-bit counter moves one step each time the clock-source tick input pulses. Two 8-bit values set the waveform: the period value and the duty value. The counter runs in one of two modes. In edge mode it counts upward and wraps. In symmetric mode it climbs to the period value and then falls back to zero. A polarity input picks the level that the output drives at the start of each period.

The period and duty inputs act as buffers. The active copies inside the block take new values only at safe points: when the counter returns to zero, while the channel is stopped, or when software clears the counter. This keeps each period whole. The enable input stops the channel as soon as it drops. When it rises, the channel waits for the next clock-source tick before it starts, so the first period after an enable can be short or long. The counter value is available as an output so that software can read it.

Top module: `pwm_chan_timer`

## Requirements
- R1: After reset the counter output reads 0, the active period and duty are 0, the channel is stopped, and `pwm_o` is the inverse of `pol_i`.
- R2: A stopped channel with `en_i` high starts running only on a cycle in which `tick_i` is high. The tick that starts the channel does not advance the counter. Every later tick while running advances it by one step.
- R3: In edge mode (`center_i`=0), each running tick sets the counter to count+1, or to 0 when count+1 is greater than or equal to the active period.
- R4: While running with a nonzero duty that is below the period, `pwm_o` equals `pol_i` while the counter is below the active duty and equals the inverse of `pol_i` otherwise. `pol_i`=1 starts each period high, and `pol_i`=0 starts it low.
- R5: In symmetric mode (`center_i`=1) with an active period P≥1, the counter rises from 0 to P and then falls back to 0, so one full period lasts 2·P ticks. With P=0 the counter stays at 0.
- R6: The active period and duty take the values of `per_i` and `dty_i` only at three points: on a running tick that brings the counter to 0, on any cycle while the channel is stopped, or on a clear strobe. A change to the inputs in the middle of a period has no effect until one of these points.
- R7: When `en_i` is low, the channel stops on the next clock edge. A stopped channel holds its counter value, and `pwm_o` is the inverse of `pol_i`.
- R8: An active duty of 0 keeps `pwm_o` at the inverse of `pol_i` for the whole period. An active duty greater than or equal to a nonzero active period keeps `pwm_o` at `pol_i` for the whole period.
- R9: A high `cnt_clr_i` clears the counter to 0 on the next edge, resets the symmetric-mode direction to upward, and loads the active period and duty from the inputs. It takes priority over a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Clock-source tick, one cycle wide |
| en_i | input | 1 | Channel enable |
| pol_i | input | 1 | Level driven at the start of each period |
| center_i | input | 1 | 1 selects symmetric (up/down) mode, 0 selects edge mode |
| per_i | input | 8 | Buffered period value |
| dty_i | input | 8 | Buffered duty value |
| cnt_clr_i | input | 1 | Clear strobe: zeroes the counter and loads the buffers |
| pwm_o | output | 1 | Waveform output |
| cnt_o | output | 8 | Current counter value |

## Verification
The bench holds `en_i` high through several cycles with no tick. A design that does not wait for the tick would start counting early and shift every later edge of the waveform. Period and duty are changed in the middle of a period. A design that loads them at once, instead of at the return to zero, would produce a broken period of the wrong length. The edge values are also covered: duty 0, duty equal to the period, period 1, and period 0 in symmetric mode. These catch an off-by-one compare that leaves a one-tick glitch, and a symmetric mode that turns around one step late and so gives a period longer than 2·P. Other runs check that the clear strobe wins over a tick and that a stopped channel holds its counter, since an error in either one leaves the counter at a value different from the one the bench predicts.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } dir_e;

  typedef struct packed {
    logic [7:0] per;
    logic [7:0] dty;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_run_gate.sv
module pwm_run_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic run_o
);
  logic run_q;

  // rises only with a tick, drops as soon as enable goes low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= en_i & (run_q | tick_i);
  end

  assign run_o = run_q;
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] dty_i,
  output logic [W-1:0] per_o,
  output logic [W-1:0] dty_o
);
  logic [W-1:0] per_q, dty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q <= '0;
      dty_q <= '0;
    end else if (load_i) begin
      per_q <= per_i;
      dty_q <= dty_i;
    end
  end

  assign per_o = per_q;
  assign dty_o = dty_q;
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         tick_i,
  input  logic         center_i,
  input  logic         clr_i,
  input  logic [W-1:0] per_i,
  output logic [W-1:0] cnt_o,
  output logic         zero_step_o
);
  localparam logic [W:0] ONE_X = {{W{1'b0}}, 1'b1};

  logic [W-1:0] cnt_q, cnt_n;
  dir_e         dir_q, dir_n;
  logic         step;
  logic [W:0]   cnt_inc;

  assign step    = run_i & tick_i & ~clr_i;
  assign cnt_inc = {1'b0, cnt_q} + ONE_X;

  always_comb begin
    cnt_n = cnt_q;
    dir_n = dir_q;
    if (!center_i) begin
      dir_n = DIR_UP;
      if (cnt_inc >= {1'b0, per_i}) cnt_n = '0;
      else                          cnt_n = cnt_inc[W-1:0];
    end else if (per_i == '0) begin
      cnt_n = '0;
      dir_n = DIR_UP;
    end else if (dir_q == DIR_UP) begin
      if (cnt_q >= per_i) begin
        // stray value above the turn point: head down
        cnt_n = cnt_q - 1'b1;
        dir_n = DIR_DN;
      end else begin
        cnt_n = cnt_inc[W-1:0];
        dir_n = (cnt_inc == {1'b0, per_i}) ? DIR_DN : DIR_UP;
      end
    end else begin
      if (cnt_q == '0) begin
        cnt_n = '0;
        dir_n = DIR_UP;
      end else begin
        cnt_n = cnt_q - 1'b1;
        dir_n = (cnt_q == {{(W-1){1'b0}}, 1'b1}) ? DIR_UP : DIR_DN;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (clr_i) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (step) begin
      cnt_q <= cnt_n;
      dir_q <= dir_n;
    end
  end

  assign cnt_o       = cnt_q;
  assign zero_step_o = step & (cnt_n == '0);
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int W = 8
) (
  input  logic         run_i,
  input  logic         pol_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] dty_i,
  output logic         pwm_o
);
  logic active;

  always_comb begin
    if (!run_i)              active = 1'b0;
    else if (dty_i == '0)    active = 1'b0;
    else if (dty_i >= per_i) active = 1'b1;
    else                     active = (cnt_i < dty_i);
  end

  assign pwm_o = active ? pol_i : ~pol_i;
endmodule

// File: rtl/pwm_chan_timer.sv
module pwm_chan_timer
  import pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         en_i,
  input  logic         pol_i,
  input  logic         center_i,
  input  logic [W-1:0] per_i,
  input  logic [W-1:0] dty_i,
  input  logic         cnt_clr_i,
  output logic         pwm_o,
  output logic [W-1:0] cnt_o
);
  logic         run_q;
  logic         zero_step;
  logic         load;
  logic [W-1:0] per_a, dty_a;
  logic [W-1:0] cnt;

  pwm_run_gate i_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (tick_i),
    .run_o  (run_q)
  );

  assign load = cnt_clr_i | ~run_q | zero_step;

  pwm_shadow #(.W(W)) i_shadow (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .per_i  (per_i),
    .dty_i  (dty_i),
    .per_o  (per_a),
    .dty_o  (dty_a)
  );

  pwm_counter #(.W(W)) i_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .run_i       (run_q),
    .tick_i      (tick_i),
    .center_i    (center_i),
    .clr_i       (cnt_clr_i),
    .per_i       (per_a),
    .cnt_o       (cnt),
    .zero_step_o (zero_step)
  );

  pwm_wave #(.W(W)) i_wave (
    .run_i (run_q),
    .pol_i (pol_i),
    .cnt_i (cnt),
    .per_i (per_a),
    .dty_i (dty_a),
    .pwm_o (pwm_o)
  );

  assign cnt_o = cnt;
endmodule

// File: rtl/pwm_chan_timer_chk.sv
module pwm_chan_timer_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         tick_i,
  input logic         en_i,
  input logic         pol_i,
  input logic         center_i,
  input logic         cnt_clr_i,
  input logic         pwm_o,
  input logic [W-1:0] cnt_o,
  input logic         run_i,
  input logic [W-1:0] per_a_i,
  input logic [W-1:0] dty_a_i
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  AST_START_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $rose(run_i)) |-> $past(tick_i)); // R2

  AST_EDGE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !cnt_clr_i && !center_i &&
     ({1'b0, cnt_o} + 1'b1 >= {1'b0, per_a_i})) |=> (cnt_o == '0)); // R3

  AST_LOAD_AT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(run_i) && !$past(cnt_clr_i) &&
     (per_a_i != $past(per_a_i) || dty_a_i != $past(dty_a_i))) |-> (cnt_o == '0)); // R6

  AST_STOP_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_clr_i) |=> (cnt_o == $past(cnt_o))); // R7

  AST_STOP_INACTIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> (pwm_o == !pol_i)); // R7

  AST_ZERO_DUTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dty_a_i == '0) |-> (pwm_o == !pol_i)); // R8

  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_clr_i |=> (cnt_o == '0)); // R9

  AST_CENTER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(center_i) && center_i && $past(cnt_o) <= $past(per_a_i) &&
     !$past(cnt_clr_i) && $past(run_i) && $stable(per_a_i)) |-> (cnt_o <= per_a_i)); // R5
endmodule

bind pwm_chan_timer pwm_chan_timer_chk #(.W(W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .en_i      (en_i),
  .pol_i     (pol_i),
  .center_i  (center_i),
  .cnt_clr_i (cnt_clr_i),
  .pwm_o     (pwm_o),
  .cnt_o     (cnt_o),
  .run_i     (run_q),
  .per_a_i   (per_a),
  .dty_a_i   (dty_a)
);

// File: tb/test_pwm_chan_timer.sv
module test_pwm_chan_timer;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic       en_i = 1'b0;
  logic       pol_i = 1'b1;
  logic       center_i = 1'b0;
  logic [7:0] per_i = 8'd0;
  logic [7:0] dty_i = 8'd0;
  logic       cnt_clr_i = 1'b0;
  logic       pwm_o;
  logic [7:0] cnt_o;

  int checks = 0;
  int fails = 0;

  typedef struct {
    logic [7:0] cnt;
    logic       pwm;
    string      tag;
  } exp_t;
  exp_t q[$];

  // reference state
  logic       m_run = 1'b0;
  logic [7:0] m_cnt = 8'd0;
  logic       m_dn = 1'b0;
  logic [7:0] m_per = 8'd0;
  logic [7:0] m_dty = 8'd0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pwm_chan_timer i_pwm_chan_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .en_i      (en_i),
    .pol_i     (pol_i),
    .center_i  (center_i),
    .per_i     (per_i),
    .dty_i     (dty_i),
    .cnt_clr_i (cnt_clr_i),
    .pwm_o     (pwm_o),
    .cnt_o     (cnt_o)
  );

  function automatic logic exp_pwm();
    logic act;
    if (!m_run)              act = 1'b0;
    else if (m_dty == 0)     act = 1'b0;
    else if (m_dty >= m_per) act = 1'b1;
    else                     act = (m_cnt < m_dty);
    return act ? pol_i : ~pol_i;
  endfunction

  // drive one cycle, advance the reference model, push the expectation
  task automatic cyc(input logic t, input logic en, input logic clr, input string tag);
    logic [7:0] n_cnt;
    logic       n_dn;
    logic       stp, ld, n_run;
    tick_i = t; en_i = en; cnt_clr_i = clr;
    stp = m_run & t & ~clr;
    n_cnt = m_cnt; n_dn = m_dn;
    if (!center_i) begin
      n_dn = 1'b0;
      n_cnt = (int'(m_cnt) + 1 >= int'(m_per)) ? 8'd0 : m_cnt + 8'd1;
    end else if (m_per == 0) begin
      n_cnt = 0; n_dn = 1'b0;
    end else if (!m_dn) begin
      if (m_cnt >= m_per) begin n_cnt = m_cnt - 8'd1; n_dn = 1'b1; end
      else begin n_cnt = m_cnt + 8'd1; n_dn = (n_cnt == m_per); end
    end else begin
      if (m_cnt == 0) begin n_cnt = 0; n_dn = 1'b0; end
      else begin n_cnt = m_cnt - 8'd1; n_dn = (n_cnt != 0); end
    end
    ld = clr | ~m_run | (stp & (n_cnt == 0));
    n_run = en & (m_run | t);
    @(posedge clk_i);
    if (ld) begin m_per = per_i; m_dty = dty_i; end
    if (clr) begin m_cnt = 0; m_dn = 1'b0; end
    else if (stp) begin m_cnt = n_cnt; m_dn = n_dn; end
    m_run = n_run;
    q.push_back('{cnt: m_cnt, pwm: exp_pwm(), tag: tag});
    @(negedge clk_i);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b1, 1'b0, tag);
  endtask

  // monitor: compare after every edge
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (cnt_o !== e.cnt || pwm_o !== e.pwm) begin
          fails++;
          $display("FAIL %s: cnt=%0d pwm=%0b expected cnt=%0d pwm=%0b",
                   e.tag, cnt_o, pwm_o, e.cnt, e.pwm);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + CLK_PERIOD/2);
    // R1 reset state
    checks++;
    if (cnt_o !== 8'd0 || pwm_o !== 1'b0) begin
      fails++;
      $display("FAIL R1: cnt=%0d pwm=%0b expected cnt=0 pwm=0", cnt_o, pwm_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    cyc(1'b0, 1'b0, 1'b0, "R1");

    // R2 enable waits for the tick
    per_i = 8'd5; dty_i = 8'd2;
    for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1, 1'b0, "R2");
    cyc(1'b1, 1'b1, 1'b0, "R2");
    cyc(1'b0, 1'b1, 1'b0, "R2");
    // R3 / R4 edge mode, high start
    ticks(12, "R3");
    pol_i = 1'b0;
    ticks(6, "R4");
    pol_i = 1'b1;

    // R6 mid-period change waits for zero
    ticks(2, "R6");
    per_i = 8'd3; dty_i = 8'd1;
    ticks(9, "R6");

    // R7 stop holds counter, output inactive
    ticks(1, "R7");
    cyc(1'b1, 1'b0, 1'b0, "R7");
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, "R7");

    // R8 duty extremes
    cyc(1'b0, 1'b0, 1'b1, "R8");
    per_i = 8'd4; dty_i = 8'd0;
    cyc(1'b1, 1'b1, 1'b0, "R8");
    ticks(5, "R8");
    cyc(1'b0, 1'b1, 1'b1, "R8");
    dty_i = 8'd4;
    cyc(1'b0, 1'b1, 1'b1, "R8");
    ticks(6, "R8");
    per_i = 8'd1; dty_i = 8'd1;
    cyc(1'b0, 1'b1, 1'b1, "R8");
    ticks(3, "R8");

    // R5 symmetric mode
    cyc(1'b0, 1'b0, 1'b1, "R5");
    center_i = 1'b1; per_i = 8'd4; dty_i = 8'd2;
    cyc(1'b0, 1'b0, 1'b1, "R5");
    cyc(1'b1, 1'b1, 1'b0, "R5");
    ticks(18, "R5");
    per_i = 8'd1; dty_i = 8'd0;
    ticks(6, "R5");
    per_i = 8'd0;
    ticks(4, "R5");

    // R9 clear beats tick, loads buffers
    per_i = 8'd6; dty_i = 8'd3;
    ticks(3, "R9");
    cyc(1'b1, 1'b1, 1'b1, "R9");
    ticks(4, "R9");
    per_i = 8'd2; dty_i = 8'd1;
    cyc(1'b1, 1'b1, 1'b1, "R9");
    ticks(5, "R9");

    // edge mode again, sparse ticks
    cyc(1'b0, 1'b0, 1'b1, "R3");
    center_i = 1'b0; per_i = 8'd3; dty_i = 8'd2;
    cyc(1'b1, 1'b1, 1'b0, "R3");
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, 1'b1, 1'b0, "R3");
      cyc(1'b0, 1'b1, 1'b0, "R3");
    end

    repeat (2) @(negedge clk_i);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule